// File: doc/BRIEF.md
# Five-Strike Watchdog Timer

This block is a watchdog built around a microsecond down-counter. Software programs a period, which is one fifth of the intended full timeout, and then starts the counter. Each time the count runs out, the block records one expiration, raises a sticky interrupt and reloads the period. A system reset pulse is issued only when the fifth expiration in a row arrives with no service in between. A service (kick) is a repeated start command. It reloads the period and clears the expiration tally.

Both the live count and the expiration tally can be read back. Software can therefore work out the time left as `count + (4 - tally) * period` microseconds. Time advances only on cycles where the `tick_us` enable input is high. The register port is a plain synchronous port that never stalls. A write takes effect on the clock edge where `reg_we` is high. A read is captured on the edge where `reg_re` is high. There is no back-pressure and no ready signal on this port.

Register map, with the address on `reg_addr`:
- 0: source-select field in bits [3:0]. It can be read and written, and has no effect on counting.
- 1: period in bits [28:0].
- 2: command register, write-only, reads as 0. Bit 0 is start/kick and bit 1 is stop.
- 3: timer status. Bits [28:0] hold the live count and bit 30 holds the interrupt flag. Writing 1 to bit 30 clears the flag.
- 4: watchdog status. Bits [14:12] hold the expiration tally.

Top module: `wdt_multi_expiry`

## Requirements
- R1: After reset, `irq` and `sys_reset` are 0, the block is stopped, and every register reads 0.
- R2: Address 0 reads back bits [3:0] of the last value written to it. Address 1 reads back bits [28:0] of the last value written to it. All other bits read 0.
- R3: Writing bit 0 = 1 to address 2 (start/kick) starts the block. It loads the count with the period and sets the tally to 0. This also applies when the block is already running.
- R4: While running, the count drops by one on each clock edge where `tick_us` is 1, and holds otherwise. While stopped, the count field (address 3, bits [28:0]) and the tally field (address 4, bits [14:12]) both read 0.
- R5: An expiration occurs when a tick arrives while the count is 1 or 0. The count then reloads the period and the tally rises by one, so while running the tally is in the range 0 to 4.
- R6: When a tick expires the count while the tally is 4, `sys_reset` is high for exactly the next cycle. On the same edge the block stops and the tally returns to 0.
- R7: Every expiration sets `irq`, which is also readable at address 3, bit 30. It stays set until a write to address 3 with bit 30 = 1. A write with bit 30 = 0 leaves it unchanged, and an expiration on the same edge as a clear wins.
- R8: Writing bit 1 = 1 to address 2 stops the block. If bits 0 and 1 are written together, stop wins.
- R9: `reg_rdata` takes the value the addressed register held just before the edge where `reg_re` is 1. It holds that value while `reg_re` is 0. Addresses 2, 5, 6 and 7 read 0.
- R10: Writing a new period while running does not change the live count. The new value is used from the next reload or start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | Microsecond count enable |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Sticky expiration interrupt |
| sys_reset | output | 1 | One-cycle system reset pulse |

## Verification
The assertions assume that `rst_n` is low at start-up and that inputs change only away from the rising edge. They place no limit on how often `tick_us` or the strobes are high, because any pattern is legal. The stimulus drives every input on the falling edge. It mixes runs of ticks, idle stretches, kicks, stops and clears, including a tick and a clear on the same edge. A behavioural model in the bench tracks count, tally, flag and read data on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned ADDR_W        = 3;
  localparam int unsigned CMD_START_BIT = 0;
  localparam int unsigned CMD_STOP_BIT  = 1;
  localparam int unsigned IRQ_BIT       = 30;
  localparam int unsigned TALLY_LSB     = 12;

  typedef enum logic [ADDR_W-1:0] {
    ADR_SRC    = 3'd0,
    ADR_PERIOD = 3'd1,
    ADR_CMD    = 3'd2,
    ADR_TSTAT  = 3'd3,
    ADR_WSTAT  = 3'd4
  } wdt_addr_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 29,
  parameter int unsigned SRC_W = 4,
  parameter int unsigned EXP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              run_en,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic [EXP_W-1:0]  tally,
  input  logic              irq_pend,
  output logic [CNT_W-1:0]  period_q,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              irq_clr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [SRC_W-1:0]  src_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_cmd;

  assign wr_cmd    = reg_we && (reg_addr == ADR_CMD);
  assign cmd_stop  = wr_cmd && reg_wdata[CMD_STOP_BIT];
  assign cmd_start = wr_cmd && reg_wdata[CMD_START_BIT] && !reg_wdata[CMD_STOP_BIT];
  assign irq_clr   = reg_we && (reg_addr == ADR_TSTAT) && reg_wdata[IRQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      period_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADR_SRC)    src_q    <= reg_wdata[SRC_W-1:0];
      if (reg_addr == ADR_PERIOD) period_q <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADR_SRC:    rd_mux[SRC_W-1:0] = src_q;
      ADR_PERIOD: rd_mux[CNT_W-1:0] = period_q;
      ADR_TSTAT: begin
        if (run_en) rd_mux[CNT_W-1:0] = live_cnt;
        rd_mux[IRQ_BIT] = irq_pend;
      end
      ADR_WSTAT:  if (run_en) rd_mux[TALLY_LSB +: EXP_W] = tally;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick_us,
  input  logic             load,
  input  logic             halt,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic at_end;

  assign at_end = (cnt_q == '0) || (cnt_q == CNT_W'(1));
  assign expire = run_en && tick_us && !load && !halt && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= period;
    end else if (run_en && tick_us && !halt) begin
      if (at_end) cnt_q <= period;
      else        cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry #(
  parameter int unsigned EXPIRATIONS = 5,
  parameter int unsigned EXP_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             halt,
  input  logic             expire,
  input  logic             irq_clr,
  output logic             run_en,
  output logic [EXP_W-1:0] tally,
  output logic             irq_pend,
  output logic             sys_reset
);
  localparam logic [EXP_W-1:0] LAST = EXP_W'(EXPIRATIONS - 1);
  logic final_hit;

  assign final_hit = expire && (tally == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en    <= 1'b0;
      tally     <= '0;
      irq_pend  <= 1'b0;
      sys_reset <= 1'b0;
    end else begin
      sys_reset <= final_hit;
      if (halt)           run_en <= 1'b0;
      else if (load)      run_en <= 1'b1;
      else if (final_hit) run_en <= 1'b0;

      if (load || final_hit) tally <= '0;
      else if (expire)       tally <= tally + EXP_W'(1);

      if (expire)       irq_pend <= 1'b1;
      else if (irq_clr) irq_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_multi_expiry.sv
module wdt_multi_expiry
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 29,
  parameter int unsigned SRC_W       = 4,
  parameter int unsigned EXPIRATIONS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_us,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sys_reset
);
  localparam int unsigned EXP_W = $clog2(EXPIRATIONS);

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] live_cnt;
  logic [EXP_W-1:0] tally;
  logic             cmd_start, cmd_stop, irq_clr;
  logic             run_en, expire;

  wdt_regs #(.CNT_W(CNT_W), .SRC_W(SRC_W), .EXP_W(EXP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .run_en(run_en),
    .live_cnt(live_cnt), .tally(tally), .irq_pend(irq),
    .period_q(period_q), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .irq_clr(irq_clr), .reg_rdata(reg_rdata)
  );

  wdt_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_us(tick_us),
    .load(cmd_start), .halt(cmd_stop), .period(period_q),
    .cnt_q(live_cnt), .expire(expire)
  );

  wdt_expiry #(.EXPIRATIONS(EXPIRATIONS), .EXP_W(EXP_W)) u_exp (
    .clk(clk), .rst_n(rst_n), .load(cmd_start), .halt(cmd_stop),
    .expire(expire), .irq_clr(irq_clr), .run_en(run_en), .tally(tally),
    .irq_pend(irq), .sys_reset(sys_reset)
  );
endmodule

// File: rtl/wdt_multi_expiry_chk.sv
module wdt_multi_expiry_chk #(
  parameter int unsigned CNT_W       = 29,
  parameter int unsigned EXPIRATIONS = 5,
  parameter int unsigned EXP_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_us,
  input logic             run_en,
  input logic [CNT_W-1:0] live_cnt,
  input logic [EXP_W-1:0] tally,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             irq,
  input logic             sys_reset
);
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> !sys_reset); // R6
  AST_RESET_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> (!run_en && tally == '0)); // R6
  AST_TALLY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tally <= EXP_W'(EXPIRATIONS - 1)); // R5
  AST_IRQ_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> irq); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick_us && !cmd_start && !cmd_stop) |=> $stable(live_cnt)); // R4
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !run_en); // R8
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (run_en && tally == '0)); // R3
endmodule

bind wdt_multi_expiry wdt_multi_expiry_chk #(
  .CNT_W(CNT_W), .EXPIRATIONS(EXPIRATIONS), .EXP_W(EXP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .run_en(run_en),
  .live_cnt(live_cnt), .tally(tally), .cmd_start(cmd_start),
  .cmd_stop(cmd_stop), .irq(irq), .sys_reset(sys_reset)
);

// File: tb/wdt_multi_expiry_test.sv
`timescale 1ns/1ps
module wdt_multi_expiry_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sys_reset;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdt_multi_expiry uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .sys_reset(sys_reset)
  );

  // behavioural reference model
  bit          m_en, m_irq, m_rst;
  int          m_cnt, m_exp, m_period, m_src;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] v = 0;
    case (a)
      3'd0: v = 32'(m_src);
      3'd1: v = 32'(m_period);
      3'd3: v = (m_en ? 32'(m_cnt) : 32'd0) | (m_irq ? 32'h4000_0000 : 32'd0);
      3'd4: v = m_en ? (32'(m_exp) << 12) : 32'd0;
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_irq = 0; m_rst = 0; m_cnt = 0; m_exp = 0;
      m_period = 0; m_src = 0; m_rdata = 0;
    end else begin
      bit stop, start, clr, hit;
      if (reg_re) m_rdata = m_read(reg_addr);
      stop  = reg_we && reg_addr == 3'd2 && reg_wdata[1];
      start = reg_we && reg_addr == 3'd2 && reg_wdata[0];
      clr   = reg_we && reg_addr == 3'd3 && reg_wdata[30];
      hit = 0; m_rst = 0;
      if (stop) m_en = 0;
      else if (start) begin m_en = 1; m_cnt = m_period; m_exp = 0; end
      else if (m_en && tick_us) begin
        if (m_cnt <= 1) begin
          hit = 1; m_cnt = m_period;
          if (m_exp == 4) begin m_en = 0; m_exp = 0; m_rst = 1; end
          else m_exp++;
        end else m_cnt--;
      end
      if (hit) m_irq = 1; else if (clr) m_irq = 0;
      if (reg_we && reg_addr == 3'd0) m_src = int'(reg_wdata[3:0]);
      if (reg_we && reg_addr == 3'd1) m_period = int'(reg_wdata[28:0]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq || sys_reset !== m_rst || reg_rdata !== m_rdata) begin
        fails++;
        $display("FAIL R7/R6/R9 model compare: actual irq=%0b rst=%0b rdata=%h expected irq=%0b rst=%0b rdata=%h",
                 irq, sys_reset, reg_rdata, m_irq, m_rst, m_rdata);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick_us = 1; end
    @(negedge clk); tick_us = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 sys_reset", {31'd0, sys_reset}, 0);
    for (int a = 0; a < 8; a++) rd(3'(a), 0, "R1 reset reads");
    // R2 readback widths
    wr(0, 32'hFFFF_FFFF); rd(0, 32'h0000_000F, "R2 source field");
    wr(1, 32'hFFFF_FFFF); rd(1, 32'h1FFF_FFFF, "R2 period field");
    wr(1, 10);
    rd(3, 0, "R4 count reads 0 while stopped");
    // R3 start
    wr(2, 1); rd(3, 10, "R3 start loads period");
    rd(4, 0, "R3 tally zero after start");
    // R4 decrement and hold
    ticks(3); rd(3, 7, "R4 three ticks");
    repeat (5) @(negedge clk); rd(3, 7, "R4 hold without tick");
    // R5 expiration
    ticks(7); rd(3, 32'h4000_000A, "R5 reload and R7 irq set");
    rd(4, 32'h0000_1000, "R5 tally one");
    // R7 write of 0 ignored, then clear
    wr(3, 0); chk("R7 zero write keeps irq", {31'd0, irq}, 1);
    wr(3, 32'h4000_0000); rd(3, 10, "R7 clear");
    // R10 period change while running
    wr(1, 4); rd(3, 10, "R10 count unchanged");
    ticks(10); rd(3, 32'h4000_0004, "R10 new period at reload");
    rd(4, 32'h0000_2000, "R5 tally two");
    // R3 kick
    wr(2, 1); rd(4, 0, "R3 kick clears tally");
    rd(3, 32'h4000_0004, "R3 kick reloads");
    wr(3, 32'h4000_0000);
    // R6 fifth expiration
    ticks(16); rd(4, 32'h0000_4000, "R5 tally four");
    chk("R6 no reset before fifth", {31'd0, sys_reset}, 0);
    ticks(3); rd(3, 32'h4000_0001, "R4 count one");
    @(negedge clk); tick_us = 1;
    @(negedge clk); tick_us = 0;
    chk("R6 reset pulse high", {31'd0, sys_reset}, 1);
    @(negedge clk);
    chk("R6 reset pulse one cycle", {31'd0, sys_reset}, 0);
    rd(4, 0, "R6 tally cleared");
    ticks(3); rd(3, 32'h4000_0000, "R6 stopped after reset");
    // R8 stop
    wr(3, 32'h4000_0000);
    wr(2, 1); ticks(2); rd(3, 2, "R8 running before stop");
    wr(2, 2); rd(3, 0, "R8 stop");
    wr(2, 3); rd(3, 0, "R8 stop wins over start");
    ticks(2); chk("R8 no irq while stopped", {31'd0, irq}, 0);
    // R7 set wins over clear
    wr(2, 1); ticks(3);
    @(negedge clk); tick_us = 1; reg_we = 1; reg_addr = 3; reg_wdata = 32'h4000_0000;
    @(negedge clk); tick_us = 0; reg_we = 0; reg_wdata = 0;
    chk("R7 set wins over clear", {31'd0, irq}, 1);
    // R9 hold and unmapped
    rd(3, 32'h4000_0004, "R9 read");
    ticks(2); chk("R9 rdata holds", reg_rdata, 32'h4000_0004);
    rd(6, 0, "R9 unmapped reads 0");
    rd(2, 0, "R9 command reads 0");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule